// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. An asynchronous pin is brought into the timer clock domain and cleaned by a programmable glitch filter. Edges on the clean level are qualified by a polarity setting. One of three event sources is chosen: the channel's own pin, the neighbouring channel's filtered level, or an internal trigger pulse. The chosen events can be divided by 1, 2, 4 or 8. Each surviving event copies the free-running timer count, which arrives as an input, into the channel's value register.

Every capture raises a capture flag. A capture that lands while that flag is still set also raises an over-capture flag. Both flags are cleared by one-cycle pulses. An interrupt request and a DMA request follow the capture flag under separate enables. A mode value of zero leaves the channel in output mode. In that mode the value register can be loaded directly and nothing is captured.

Top module: `tmr_capture_chan`

## Requirements
- R1: The pin passes through two synchroniser flops and then the filter register. With a filter length of 0, a pin edge driven while the count reads C captures the value C+3.
- R2: With a filter length N of 1 or more, the filtered level changes only after the synchronised pin has differed from it for N consecutive clocks. A capture from a held pin edge stores C+2+N. A pulse shorter than N clocks produces no capture.
- R3: The two-bit polarity field selects the qualifying edges: 2'b00 and 2'b10 take rising edges, 2'b01 takes falling edges, and 2'b11 takes both.
- R4: Mode 1 captures on the own pin edge. Mode 2 captures on an edge of the neighbour's filtered level. Mode 3 captures on a trigger pulse. The sources that are not selected have no effect. Neighbour and trigger events driven while the count reads C store C.
- R5: In mode 0 there is no capture, and a write strobe loads the write data into the value register on the next clock. In modes 1 to 3, writes leave the register unchanged.
- R6: The prescale field p makes every (2^p)-th qualifying event effective. The event count restarts when the channel is disabled or when p changes.
- R7: An effective event with the channel enabled stores the count and sets the capture flag. With the enable low, nothing is stored. After reset the value register and both flags are zero.
- R8: A capture that occurs while the capture flag is already set also sets the over-capture flag.
- R9: A clear pulse resets its flag on the next clock. When a capture coincides with a capture-flag clear, the flag stays set.
- R10: The interrupt request equals the capture flag ANDed with the interrupt enable. The DMA request equals the capture flag ANDed with the DMA enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous channel pin |
| nbr_filt | input | 1 | Neighbouring channel's filtered level |
| trig_in | input | 1 | Internal trigger pulse, synchronous |
| cnt_val | input | CNT_W | Free-running timer count |
| cfg_en | input | 1 | Channel enable |
| cfg_mode | input | 2 | 0 output, 1 own pin, 2 neighbour, 3 trigger |
| cfg_pol | input | 2 | Edge polarity selection |
| cfg_psc | input | 2 | Event prescale exponent |
| cfg_flt | input | FLT_W | Filter length in clocks |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_de | input | 1 | DMA request enable |
| wr_en | input | 1 | Value register write strobe |
| wr_data | input | CNT_W | Value register write data |
| clr_cf | input | 1 | Capture flag clear pulse |
| clr_of | input | 1 | Over-capture flag clear pulse |
| ccv_out | output | CNT_W | Capture/compare value register |
| filt_out | output | 1 | Own filtered level, for the neighbour |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Over-capture flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A filter counter or synchroniser that is off by one cycle shows up at the next capture. The stored count then differs from the expected C+3 or C+2+N. A prescaler count that is not cleared makes a capture appear one event early or late. Because every change of the value register is matched against a queue of predicted values, any extra, missing or mistimed capture is detected at the clock edge where the register changes. Flag faults are visible one clock after the capture or clear that should have moved them.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SRC_OUT = 2'd0,
    SRC_OWN = 2'd1,
    SRC_NBR = 2'd2,
    SRC_TRG = 2'd3
  } cap_src_e;

  // Number of events minus one that make up one effective event.
  function automatic logic [2:0] psc_limit(input logic [1:0] p);
    return 3'((4'd1 << p) - 4'd1);
  endfunction

  // Polarity decode: 01 falling, 11 both, otherwise rising.
  function automatic logic edge_pick(input logic [1:0] pol, input logic r, input logic f);
    case (pol)
      2'b01:   return f;
      2'b11:   return r | f;
      default: return r;
    endcase
  endfunction
endpackage

// File: rtl/cap_sync_filter.sv
module cap_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FLT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [FLT_W-1:0] flt_n,
  output logic             dout
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic                   synced;
  logic [FLT_W-1:0]       run_q;
  logic                   flt_q;
  logic                   run_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-2:0], din};
  end
  assign synced = sh_q[SYNC_STAGES-1];

  assign run_hit = ({1'b0, run_q} + 1'b1) >= {1'b0, flt_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      run_q <= '0;
    end else if (flt_n == '0) begin
      flt_q <= synced;
      run_q <= '0;
    end else if (synced == flt_q) begin
      run_q <= '0;
    end else if (run_hit) begin
      flt_q <= synced;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
  assign dout = flt_q;

  a_r2_hold_when_matching: assert property (@(posedge clk) disable iff (!rst_n)
    (synced == flt_q) |=> $stable(flt_q));
endmodule

// File: rtl/cap_edge.sv
module cap_edge import cap_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] pol,
  output logic       evt
);
  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
  assign evt  = edge_pick(pol, rise, fall);
endmodule

// File: rtl/cap_prescale.sv
module cap_prescale import cap_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] psc,
  input  logic       evt,
  output logic       eff
);
  logic [1:0] psc_q;
  logic [2:0] cnt_q;
  logic [2:0] lim;
  logic       restart;

  assign lim     = psc_limit(psc);
  assign restart = !en || (psc != psc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else begin
      psc_q <= psc;
      if (restart)  cnt_q <= '0;
      else if (evt) cnt_q <= (cnt_q == lim) ? 3'd0 : cnt_q + 3'd1;
    end
  end

  assign eff = !restart && evt && (cnt_q == lim);

  a_r6_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == 3'd0));
endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan import cap_pkg::*; #(
  parameter int CNT_W       = 16,
  parameter int FLT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             nbr_filt,
  input  logic             trig_in,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_pol,
  input  logic [1:0]       cfg_psc,
  input  logic [FLT_W-1:0] cfg_flt,
  input  logic             cfg_ie,
  input  logic             cfg_de,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr_cf,
  input  logic             clr_of,
  output logic [CNT_W-1:0] ccv_out,
  output logic             filt_out,
  output logic             cap_flag,
  output logic             ovr_flag,
  output logic             irq,
  output logic             dma_req
);
  cap_src_e         src;
  logic             in_mode;
  logic             own_evt;
  logic             nbr_evt;
  logic             src_evt;
  logic             cap_evt;
  logic [CNT_W-1:0] ccv_q;
  logic             cf_q;
  logic             of_q;

  assign src     = cap_src_e'(cfg_mode);
  assign in_mode = (src != SRC_OUT);

  cap_sync_filter #(.SYNC_STAGES(SYNC_STAGES), .FLT_W(FLT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .flt_n(cfg_flt), .dout(filt_out)
  );

  cap_edge u_own_edge (
    .clk(clk), .rst_n(rst_n), .lvl(filt_out), .pol(cfg_pol), .evt(own_evt)
  );

  cap_edge u_nbr_edge (
    .clk(clk), .rst_n(rst_n), .lvl(nbr_filt), .pol(cfg_pol), .evt(nbr_evt)
  );

  always_comb begin
    case (src)
      SRC_OWN: src_evt = own_evt;
      SRC_NBR: src_evt = nbr_evt;
      SRC_TRG: src_evt = trig_in;
      default: src_evt = 1'b0;
    endcase
  end

  cap_prescale u_psc (
    .clk(clk), .rst_n(rst_n), .en(cfg_en && in_mode), .psc(cfg_psc),
    .evt(src_evt), .eff(cap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccv_q <= '0;
      cf_q  <= 1'b0;
      of_q  <= 1'b0;
    end else begin
      if (cap_evt)                ccv_q <= cnt_val;
      else if (!in_mode && wr_en) ccv_q <= wr_data;
      if (cap_evt)     cf_q <= 1'b1;
      else if (clr_cf) cf_q <= 1'b0;
      if (cap_evt && cf_q) of_q <= 1'b1;
      else if (clr_of)     of_q <= 1'b0;
    end
  end

  assign ccv_out  = ccv_q;
  assign cap_flag = cf_q;
  assign ovr_flag = of_q;
  assign irq      = cf_q & cfg_ie;
  assign dma_req  = cf_q & cfg_de;

  a_r7_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);
  a_r8_overcapture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cap_flag) |=> ovr_flag);
  a_r9_clear_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cf && !cap_evt) |=> !cap_flag);
  a_r5_ccv_held_in_input_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !cap_evt) |=> $stable(ccv_out));
endmodule

// File: tb/tmr_capture_chan_bench.sv
`timescale 1ns/1ps
module tmr_capture_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0, nbr_filt = 1'b0, trig_in = 1'b0;
  logic [15:0] cnt = '0;
  logic        cfg_en = 1'b0, cfg_ie = 1'b0, cfg_de = 1'b0;
  logic [1:0]  cfg_mode = 2'd0, cfg_pol = 2'd0, cfg_psc = 2'd0;
  logic [3:0]  cfg_flt = 4'd0;
  logic        wr_en = 1'b0, clr_cf = 1'b0, clr_of = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ccv_out;
  logic        filt_out, cap_flag, ovr_flag, irq, dma_req;

  int          checks = 0, errors = 0, cyc = 0;
  bit          done = 0;
  logic [15:0] expq[$];
  logic [15:0] last_ccv = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  tmr_capture_chan u_tmr_capture_chan (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .nbr_filt(nbr_filt), .trig_in(trig_in),
    .cnt_val(cnt), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
    .cfg_psc(cfg_psc), .cfg_flt(cfg_flt), .cfg_ie(cfg_ie), .cfg_de(cfg_de),
    .wr_en(wr_en), .wr_data(wr_data), .clr_cf(clr_cf), .clr_of(clr_of),
    .ccv_out(ccv_out), .filt_out(filt_out), .cap_flag(cap_flag), .ovr_flag(ovr_flag),
    .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] v);
    expq.push_back(v);
  endtask

  // Monitor: every change of the value register is matched to a prediction.
  always @(negedge clk) begin
    if (rst_n && ccv_out !== last_ccv) begin
      last_ccv = ccv_out;
      if (expq.size() == 0) chk("R4 unexpected capture", {16'd0, ccv_out}, 32'hFFFF_FFFF);
      else chk("R7 captured value", {16'd0, ccv_out}, {16'd0, expq.pop_front()});
    end
  end

  task automatic pin_to(input logic v, input bit expect_cap, input int lat);
    @(negedge clk);
    pin_in = v;
    if (expect_cap) push(cnt + 16'(lat));
    step(lat + 4);
  endtask

  task automatic trig_pulse(input bit expect_cap);
    @(negedge clk);
    trig_in = 1'b1;
    if (expect_cap) push(cnt);
    @(negedge clk);
    trig_in = 1'b0;
    step(3);
  endtask

  task automatic nbr_to(input logic v, input bit expect_cap);
    @(negedge clk);
    nbr_filt = v;
    if (expect_cap) push(cnt);
    step(4);
  endtask

  task automatic clear_flags;
    @(negedge clk);
    clr_cf = 1'b1; clr_of = 1'b1;
    @(negedge clk);
    clr_cf = 1'b0; clr_of = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R7 reset state
    chk("R7 reset value", {16'd0, ccv_out}, 32'd0);
    chk("R7 reset flag", {31'd0, cap_flag}, 32'd0);
    chk("R8 reset ovr", {31'd0, ovr_flag}, 32'd0);
    chk("R10 reset irq", {31'd0, irq}, 32'd0);

    // R1 own pin, rising, no filter
    cfg_mode = 2'd1; cfg_en = 1'b1; cfg_ie = 1'b1;
    step(2);
    pin_to(1'b1, 1, 3);
    chk("R7 flag after capture", {31'd0, cap_flag}, 32'd1);
    chk("R10 irq", {31'd0, irq}, 32'd1);
    chk("R10 dma off", {31'd0, dma_req}, 32'd0);
    pin_to(1'b0, 0, 3); // R3 falling ignored on rising polarity
    pin_to(1'b1, 1, 3);
    chk("R8 over-capture", {31'd0, ovr_flag}, 32'd1);
    cfg_de = 1'b1;
    step(1);
    chk("R10 dma on", {31'd0, dma_req}, 32'd1);
    clear_flags();
    chk("R9 cleared flag", {31'd0, cap_flag}, 32'd0);
    chk("R9 cleared ovr", {31'd0, ovr_flag}, 32'd0);
    chk("R10 dma follows flag", {31'd0, dma_req}, 32'd0);

    // R9 clear and capture in the same cycle: capture wins
    pin_to(1'b0, 0, 3);
    @(negedge clk);
    pin_in = 1'b1;
    push(cnt + 16'd3);
    step(3);
    clr_cf = 1'b1;
    @(negedge clk);
    clr_cf = 1'b0;
    chk("R9 capture wins over clear", {31'd0, cap_flag}, 32'd1);
    step(3);

    // R3 polarity modes
    cfg_pol = 2'b01;
    pin_to(1'b0, 1, 3);
    pin_to(1'b1, 0, 3);
    cfg_pol = 2'b11;
    pin_to(1'b0, 1, 3);
    pin_to(1'b1, 1, 3);
    cfg_pol = 2'b10;
    pin_to(1'b0, 0, 3);
    pin_to(1'b1, 1, 3);
    pin_to(1'b0, 0, 3);

    // R2 filter length 4
    cfg_pol = 2'b00; cfg_flt = 4'd4;
    step(2);
    @(negedge clk); pin_in = 1'b1;
    step(3);        pin_in = 1'b0;
    step(10);
    chk("R2 glitch rejected", {31'd0, filt_out}, 32'd0);
    pin_to(1'b1, 1, 6);
    pin_to(1'b0, 0, 6);
    cfg_flt = 4'd0;

    // R4 neighbour source; own pin and trigger ignored
    cfg_mode = 2'd2;
    step(2);
    pin_to(1'b1, 0, 3);
    pin_to(1'b0, 0, 3);
    trig_pulse(0);
    nbr_to(1'b1, 1);
    nbr_to(1'b0, 0);
    // R4 trigger source; neighbour ignored
    cfg_mode = 2'd3;
    step(2);
    nbr_to(1'b1, 0);
    nbr_to(1'b0, 0);
    trig_pulse(1);

    // R6 prescale by 4, then restart on disable
    cfg_psc = 2'd2;
    step(2);
    trig_pulse(0); trig_pulse(0); trig_pulse(0);
    trig_pulse(1);
    cfg_psc = 2'd1;
    step(2);
    trig_pulse(0);
    cfg_en = 1'b0;
    step(2);
    cfg_en = 1'b1;
    step(1);
    trig_pulse(0);
    trig_pulse(1);
    // R6 restart on prescale change
    trig_pulse(0);
    cfg_psc = 2'd2;
    step(2);
    cfg_psc = 2'd1;
    step(2);
    trig_pulse(0);
    trig_pulse(1);
    cfg_psc = 2'd0;
    step(2);

    // R7 disabled channel stores nothing
    cfg_en = 1'b0;
    step(1);
    trig_pulse(0);
    chk("R7 no capture when disabled", {16'd0, ccv_out}, {16'd0, last_ccv});
    cfg_en = 1'b1;

    // R5 output mode: writes load, trigger ignored
    cfg_mode = 2'd0;
    step(2);
    trig_pulse(0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h1234; push(16'h1234);
    @(negedge clk);
    wr_en = 1'b0;
    step(2);
    chk("R5 write in output mode", {16'd0, ccv_out}, 32'h1234);
    cfg_mode = 2'd3;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'hBEEF;
    @(negedge clk);
    wr_en = 1'b0;
    step(2);
    chk("R5 write ignored in input mode", {16'd0, ccv_out}, 32'h1234);

    step(10);
    chk("R4 all predicted captures seen", expq.size(), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule